// File: doc/BRIEF.md
# Configurable GPIO port controller

This block controls one 8-bit general-purpose I/O port of a small microcontroller. Each pin is set on its own to one of four output types: quasi-bidirectional, push-pull, open drain or input-only. For every pin the block produces three separate pad enables: strong pull-down, strong pull-up and weak pull-up. It also takes the pad level back in and passes it through a glitch filter. The filtered value is what software reads.

A small register bus gives access to the port latch and to two mode registers. The two mode bits of a pin, one from each register, select its output type. Two pins are limited by parameters. One pin can only be an input. A second pin allows only input-only or open drain, and a write that would make it drive high falls back to input-only.

Each pin's glitch filter is a four-state machine:
- `FLT_HI`: stable high.
- `FLT_FALL`: one low sample seen.
- `FLT_LO`: stable low.
- `FLT_RISE`: one high sample seen.

The transitions are:
- `FLT_HI` to `FLT_FALL` on a low sample.
- `FLT_FALL` to `FLT_LO` on a second low sample, or back to `FLT_HI` on a high sample.
- `FLT_LO` to `FLT_RISE` on a high sample.
- `FLT_RISE` to `FLT_HI` on a second high sample, or back to `FLT_LO` on a low sample.

The filtered level is high in `FLT_HI` and `FLT_FALL`.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset the latch reads 0xFF, mode register A reads 0xFF, mode register B reads 0x00, the port reads 0xFF, and every pad enable is 0.
- R2: Address 0 writes the latch and reads the filtered pads. Address 1 reads the latch. Address 2 reads and writes mode register A, and address 3 reads and writes mode register B. A write takes effect at the next rising clock edge. Reads are combinational.
- R3: The mode of pin i is {A[i], B[i]}: 00 quasi-bidirectional, 01 push-pull, 10 input-only with no enable active, 11 open drain.
- R4: In quasi-bidirectional mode, latch 1 enables only the weak pull-up and latch 0 enables only the strong pull-down.
- R5: In push-pull mode, latch 1 enables only the strong pull-up and latch 0 enables only the strong pull-down. No pin ever has the strong pull-up and the strong pull-down enabled together.
- R6: In open-drain mode, latch 0 enables the strong pull-down. No pull-up is ever enabled in this mode.
- R7: Pin IN_ONLY_PIN (default 5) always reads A=1 and B=0, whatever is written, and all three of its enables stay 0.
- R8: For pin OD_ONLY_PIN (default 2), a write whose resulting pair would be 00 or 01 stores 10 (input-only) in both registers instead. Pairs 10 and 11 are stored as requested.
- R9: A filtered input takes a new pad level only after that level has been sampled at 2 consecutive rising edges. It changes at the second of those edges, and a level that lasts a single cycle is dropped.
- R10: A port read in quasi-bidirectional mode returns the filtered pad level, not the latch. This holds even in the cycle in which the latch is being written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| pad_in | input | 8 | Pad input levels |
| pd_en | output | 8 | Strong pull-down enable per pin |
| pus_en | output | 8 | Strong pull-up enable per pin |
| puw_en | output | 8 | Weak pull-up enable per pin |

## Verification
Two functions can meet in one cycle: a latch write through address 0 and a read of that same address. The read must show the filtered pads, while the write changes only the latch and the pad enables.

The bench provokes this case with all pins quasi-bidirectional, the latch at ones and the pads held at a pattern different from the write data. It then asserts the write strobe while sampling the read data. It judges the result from three observations: the read data equals the pad pattern, the latch reads back the written data after the edge, and the pull-down enables follow the new latch.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    typedef enum logic [1:0] {
        MODE_QB = 2'b00,
        MODE_PP = 2'b01,
        MODE_IN = 2'b10,
        MODE_OD = 2'b11
    } pin_mode_e;

    typedef enum logic [1:0] {
        FLT_HI   = 2'b00,
        FLT_FALL = 2'b01,
        FLT_LO   = 2'b10,
        FLT_RISE = 2'b11
    } flt_state_e;

    localparam int ADDR_W = 2;
    localparam logic [ADDR_W-1:0] ADDR_PORT  = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_LATCH = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_CFGA  = 2'd2;
    localparam logic [ADDR_W-1:0] ADDR_CFGB  = 2'd3;
endpackage

// File: rtl/gpio_glitch_filter.sv
module gpio_glitch_filter
    import gpio_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pad,
    output logic level
);
    flt_state_e state, state_nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= FLT_HI;
        else        state <= state_nxt;
    end

    // next state
    always_comb begin
        unique case (state)
            FLT_HI:   state_nxt = pad ? FLT_HI : FLT_FALL;
            FLT_FALL: state_nxt = pad ? FLT_HI : FLT_LO;
            FLT_LO:   state_nxt = pad ? FLT_RISE : FLT_LO;
            FLT_RISE: state_nxt = pad ? FLT_HI : FLT_LO;
            default:  state_nxt = FLT_HI;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state)
            FLT_HI, FLT_FALL: level = 1'b1;
            FLT_LO, FLT_RISE: level = 1'b0;
            default:          level = 1'b1;
        endcase
    end

    // R9: a change needs the new level on the two previous samples
    a_r9_two_samples: assert property (@(posedge clk) disable iff (!rst_n)
        (level != $past(level)) |-> ($past(pad) == level && $past(pad, 2) == level));
endmodule

// File: rtl/gpio_mode_regs.sv
module gpio_mode_regs #(
    parameter int WIDTH       = 8,
    parameter int IN_ONLY_PIN = 5,
    parameter int OD_ONLY_PIN = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_a,
    input  logic             wr_b,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] cfg_a,
    output logic [WIDTH-1:0] cfg_b
);
    logic [WIDTH-1:0] nxt_a, nxt_b;

    always_comb begin
        for (int i = 0; i < WIDTH; i++) begin
            logic req_a, req_b;
            req_a = wr_a ? wdata[i] : cfg_a[i];
            req_b = wr_b ? wdata[i] : cfg_b[i];
            if (i == IN_ONLY_PIN) begin
                nxt_a[i] = 1'b1;
                nxt_b[i] = 1'b0;
            end else if (i == OD_ONLY_PIN && !req_a) begin
                nxt_a[i] = 1'b1;
                nxt_b[i] = 1'b0;
            end else begin
                nxt_a[i] = req_a;
                nxt_b[i] = req_b;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_a <= '1;
            cfg_b <= '0;
        end else begin
            cfg_a <= nxt_a;
            cfg_b <= nxt_b;
        end
    end

    // R7: the input-only pin keeps its fixed pair
    a_r7_fixed_pair: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_a[IN_ONLY_PIN] && !cfg_b[IN_ONLY_PIN]);
    // R8: the restricted pin never holds a driving-high mode
    a_r8_od_legal: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_a[OD_ONLY_PIN]);
endmodule

// File: rtl/gpio_pin_drive.sv
module gpio_pin_drive
    import gpio_pkg::*;
(
    input  pin_mode_e mode,
    input  logic      latch,
    output logic      pd,
    output logic      pus,
    output logic      puw
);
    always_comb begin
        pd  = 1'b0;
        pus = 1'b0;
        puw = 1'b0;
        unique case (mode)
            MODE_QB: begin pd = !latch; puw = latch; end
            MODE_PP: begin pd = !latch; pus = latch; end
            MODE_IN: ;
            MODE_OD: pd = !latch;
            default: ;
        endcase
    end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int IN_ONLY_PIN = 5,
    parameter int OD_ONLY_PIN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pad_in,
    output logic [WIDTH-1:0]  pd_en,
    output logic [WIDTH-1:0]  pus_en,
    output logic [WIDTH-1:0]  puw_en
);
    logic [WIDTH-1:0] latch_q, cfg_a, cfg_b, filt;
    logic wr_port, wr_a, wr_b;

    assign wr_port = bus_we && (bus_addr == ADDR_PORT);
    assign wr_a    = bus_we && (bus_addr == ADDR_CFGA);
    assign wr_b    = bus_we && (bus_addr == ADDR_CFGB);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       latch_q <= '1;
        else if (wr_port) latch_q <= bus_wdata;
    end

    gpio_mode_regs #(
        .WIDTH(WIDTH), .IN_ONLY_PIN(IN_ONLY_PIN), .OD_ONLY_PIN(OD_ONLY_PIN)
    ) u_modes (
        .clk(clk), .rst_n(rst_n), .wr_a(wr_a), .wr_b(wr_b),
        .wdata(bus_wdata), .cfg_a(cfg_a), .cfg_b(cfg_b)
    );

    for (genvar g = 0; g < WIDTH; g++) begin : g_pin
        pin_mode_e mode;
        assign mode = pin_mode_e'({cfg_a[g], cfg_b[g]});

        gpio_glitch_filter u_filt (
            .clk(clk), .rst_n(rst_n), .pad(pad_in[g]), .level(filt[g])
        );

        gpio_pin_drive u_drv (
            .mode(mode), .latch(latch_q[g]),
            .pd(pd_en[g]), .pus(pus_en[g]), .puw(puw_en[g])
        );

        // R6: open drain never pulls up
        a_r6_od_no_pull: assert property (@(posedge clk) disable iff (!rst_n)
            (mode == MODE_OD) |-> (!pus_en[g] && !puw_en[g]));
        // R4: quasi-bidirectional high is weak only
        a_r4_qb_weak: assert property (@(posedge clk) disable iff (!rst_n)
            (mode == MODE_QB && latch_q[g]) |-> (puw_en[g] && !pus_en[g] && !pd_en[g]));
    end

    always_comb begin
        unique case (bus_addr)
            ADDR_PORT:  bus_rdata = filt;
            ADDR_LATCH: bus_rdata = latch_q;
            ADDR_CFGA:  bus_rdata = cfg_a;
            ADDR_CFGB:  bus_rdata = cfg_b;
            default:    bus_rdata = filt;
        endcase
    end

    // R5: strong drivers never fight
    a_r5_no_fight: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_en & pus_en) == '0);
    // R7: the input-only pin never drives
    a_r7_inonly_off: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_en[IN_ONLY_PIN] && !pus_en[IN_ONLY_PIN] && !puw_en[IN_ONLY_PIN]);
    // R2: a port write lands in the latch at the next edge
    a_r2_latch_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_port |=> (latch_q == $past(bus_wdata)));
endmodule

// File: tb/tb_gpio_port_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_port_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] pad_in = 8'hFF;
    logic [7:0] pd_en, pus_en, puw_en;

    int checks = 0;
    int failures = 0;
    logic [7:0] m_a = 8'hFF, m_b = 8'h00, m_lat = 8'hFF;

    localparam int IN_PIN = 5;
    localparam int OD_PIN = 2;
    localparam int NVEC = 6;
    // {mode A, mode B, latch}
    localparam logic [23:0] VEC [NVEC] = '{
        24'h00_00_A5, 24'h00_FF_3C, 24'hFF_FF_0F,
        24'hFF_00_00, 24'hF0_CC_96, 24'h0F_55_5A
    };

    always #4 clk = ~clk;

    gpio_port_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pd_en(pd_en), .pus_en(pus_en), .puw_en(puw_en)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // model of R7/R8 write rules
    task automatic model_write(input logic [1:0] a, input logic [7:0] d);
        if (a == 2'd0) m_lat = d;
        else if (a >= 2'd2) begin
            for (int i = 0; i < 8; i++) begin
                logic ra, rb;
                ra = (a == 2'd2) ? d[i] : m_a[i];
                rb = (a == 2'd3) ? d[i] : m_b[i];
                if (i == IN_PIN || (i == OD_PIN && !ra)) begin ra = 1'b1; rb = 1'b0; end
                m_a[i] = ra;
                m_b[i] = rb;
            end
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
        model_write(a, d);
    endtask

    task automatic rd(input logic [1:0] a, input string tag, input logic [7:0] exp);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    // R3..R6 expected enables from the model
    task automatic chk_drive(input string tag);
        logic [7:0] epd, epus, epuw;
        for (int i = 0; i < 8; i++) begin
            epd[i] = 1'b0; epus[i] = 1'b0; epuw[i] = 1'b0;
            case ({m_a[i], m_b[i]})
                2'b00: begin epd[i] = !m_lat[i]; epuw[i] = m_lat[i]; end
                2'b01: begin epd[i] = !m_lat[i]; epus[i] = m_lat[i]; end
                2'b11: epd[i] = !m_lat[i];
                default: ;
            endcase
        end
        chk({tag, " pd"}, pd_en, epd);
        chk({tag, " pus"}, pus_en, epus);
        chk({tag, " puw"}, puw_en, epuw);
    endtask

    initial begin
        #(200000 * 8);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state, checked while reset is held
        rd(2'd1, "R1 latch", 8'hFF);
        rd(2'd2, "R1 modeA", 8'hFF);
        rd(2'd3, "R1 modeB", 8'h00);
        rd(2'd0, "R1 port", 8'hFF);
        chk("R1 pd", pd_en, 8'h00);
        chk("R1 pus", pus_en, 8'h00);
        chk("R1 puw", puw_en, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        // R7/R8: all quasi-bidirectional requested, two pins fall back
        bus_write(2'd2, 8'h00);
        rd(2'd2, "R8 modeA fallback", 8'h24);
        rd(2'd3, "R7 modeB", 8'h00);
        chk("R4 puw qb", puw_en, 8'hDB);
        chk("R7 pd", pd_en, 8'h00);

        // R8: open drain everywhere, then request push-pull
        bus_write(2'd2, 8'hFF);
        bus_write(2'd3, 8'hFF);
        rd(2'd3, "R7 modeB fixed", 8'hDF);
        bus_write(2'd2, 8'h00);
        rd(2'd2, "R8 modeA", 8'h24);
        rd(2'd3, "R8 modeB", 8'hDB);
        chk_drive("R5 pp");

        // R9 glitch filter timing
        pad_in = 8'h00;
        @(negedge clk); rd(2'd0, "R9 one sample", 8'hFF);
        @(negedge clk); rd(2'd0, "R9 two samples", 8'h00);
        pad_in = 8'hF0;
        @(negedge clk); pad_in = 8'h00;
        @(negedge clk); rd(2'd0, "R9 pulse dropped", 8'h00);
        @(negedge clk); rd(2'd0, "R9 pulse dropped late", 8'h00);
        pad_in = 8'h0F;
        repeat (2) @(negedge clk);
        rd(2'd0, "R9 pattern", 8'h0F);

        // R10: quasi-bidirectional, write latch and read port in one cycle
        bus_write(2'd2, 8'h00);
        bus_write(2'd3, 8'h00);
        bus_write(2'd0, 8'hFF);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 2'd0; bus_wdata = 8'h33;
        #1;
        chk("R10 port during write", bus_rdata, 8'h0F);
        @(negedge clk);
        bus_we = 1'b0;
        model_write(2'd0, 8'h33);
        rd(2'd0, "R10 port after write", 8'h0F);
        rd(2'd1, "R2 latch readback", 8'h33);
        chk_drive("R4 qb after write");

        // vector table, R3..R6 and R2
        for (int v = 0; v < NVEC; v++) begin
            bus_write(2'd2, VEC[v][23:16]);
            bus_write(2'd3, VEC[v][15:8]);
            bus_write(2'd0, VEC[v][7:0]);
            rd(2'd2, "R2 modeA", m_a);
            rd(2'd3, "R2 modeB", m_b);
            rd(2'd1, "R2 latch", m_lat);
            chk_drive("R3 vector");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule